// File: doc/BRIEF.md
# Flux Transition Write Precompensation Unit

This unit sits between an encoder that produces a serial stream of recording-cell bits and the write-data line of a floppy drive. For every cell that carries a flux transition it emits one fixed-width write pulse. The pulse is timed on a fast clock at a fixed multiple of the data rate. On inner tracks, where bits are packed densely and read-back peaks drift, it moves a transition a programmable number of fast-clock ticks early or late. The direction comes from whether the neighbouring cells also carry transitions. All timing is counted from the clock, so no analog delay element is involved.

The encoder presents one cell bit per cell period, qualified by a one-cycle `bit_valid` strobe. A three-cell window made of the previous, current and next cells decides the shift for the current cell. Because the next cell has to be known first, the output runs one cell behind the input. A separate flag tells the drive to lower its write current whenever the head is on an inner track. That flag follows the track number alone.

Top module: `flux_precomp`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is sampled high, `wr_pulse` and `reduce_current` are 0.
- R2: `reduce_current` equals (`track` > 43) as sampled one clock earlier, whatever the value of `enable`.
- R3: A cell bit of 1 produces exactly one `wr_pulse` of 4 consecutive clock cycles. A cell bit of 0 produces no pulse.
- R4: Strobes arrive every 16 clocks. A bit sampled on strobe k is emitted in the cell that strobe k+1 opens. If that cell's pulse starts at offset s (0..15), `wr_pulse` is high after clock edges S+s+1 through S+s+4, where S is the edge of strobe k+1. The nominal offset is 6, which centres the pulse in the cell.
- R5: With precompensation active, a 1 cell whose previous cell is 1 and next cell is 0 starts at offset 6 + step (late).
- R6: With precompensation active, a 1 cell whose previous cell is 0 and next cell is 1 starts at offset 6 − step (early).
- R7: A 1 cell whose two neighbours are equal (both 0 or both 1) is always sent at offset 6.
- R8: Precompensation is active only when `track` > 43. At `track` = 43 every pulse is at offset 6, even with `enable` high.
- R9: With `enable` low every pulse is at offset 6, whatever the track.
- R10: `step_cfg` values above 6 act as 6. A `step_cfg` of 0 leaves every pulse at offset 6.
- R11: When strobes stop, no further pulses appear after the pulse of the last opened cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 16 ticks per cell |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows precompensation shifting |
| track | input | 8 | Current head track number |
| step_cfg | input | 3 | Shift amount in clock ticks |
| bit_valid | input | 1 | One-cycle strobe that opens a cell and accepts `bit_in` |
| bit_in | input | 1 | Cell bit (1 = flux transition) |
| wr_pulse | output | 1 | Timed write pulse train |
| reduce_current | output | 1 | Lower write current on inner tracks |

## Verification
The hardest situations to reach are the shifted cells. The early and late shifts need a particular pair of neighbour bits around a 1, and they show up only when the enable, the track and the step are all set in a particular way. The stimulus feeds a cyclic order-3 binary sequence that contains every three-cell neighbourhood. It does so under several track, enable and step combinations, including track 43 and 44 and a step above the clamp. Each cell's 16-tick output is compared with a pulse position computed from the neighbours. The largest late offset places the pulse's last tick on the edge that also opens the next cell, so that case is covered too.

// File: rtl/flux_precomp_pkg.sv
package flux_precomp_pkg;

    typedef enum logic [1:0] {
        SHIFT_NONE  = 2'd0,
        SHIFT_EARLY = 2'd1,
        SHIFT_LATE  = 2'd2
    } shift_e;

    typedef struct packed {
        logic prev;
        logic cur;
        logic next;
    } cell_win_t;

    typedef struct packed {
        logic   fire;
        shift_e dir;
    } cell_class_t;

    // Decide whether a cell fires and which way its transition moves.
    function automatic cell_class_t classify_cell(input cell_win_t w);
        cell_class_t c;
        c.fire = w.cur;
        if (!w.cur)
            c.dir = SHIFT_NONE;
        else if (w.prev && !w.next)
            c.dir = SHIFT_LATE;
        else if (!w.prev && w.next)
            c.dir = SHIFT_EARLY;
        else
            c.dir = SHIFT_NONE;
        return c;
    endfunction

endpackage

// File: rtl/flux_precomp_window.sv
module flux_precomp_window
    import flux_precomp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  logic        bit_in,
    output cell_class_t cls_next
);

    // hist_q[1] = cell before current, hist_q[0] = current cell.
    logic [1:0] hist_q;
    cell_win_t  win;

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else if (strobe)
            hist_q <= {hist_q[0], bit_in};
    end

    // Window as it stands once the arriving bit is accepted.
    always_comb begin
        win.prev = hist_q[1];
        win.cur  = hist_q[0];
        win.next = bit_in;
        cls_next = classify_cell(win);
    end

endmodule

// File: rtl/flux_precomp_zone.sv
module flux_precomp_zone #(
    parameter int TRK_W       = 8,
    parameter int STEP_W      = 3,
    parameter int TRACK_LIMIT = 43,
    parameter int MAX_STEP    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [TRK_W-1:0]  track,
    input  logic [STEP_W-1:0] step_cfg,
    output logic              zone_active,
    output logic [STEP_W-1:0] eff_step,
    output logic              reduce_current
);

    localparam logic [TRK_W-1:0]  LIMIT_V = TRK_W'(TRACK_LIMIT);
    localparam logic [STEP_W-1:0] CLAMP_V = STEP_W'(MAX_STEP);

    logic inner;

    always_comb begin
        inner       = track > LIMIT_V;
        zone_active = enable && inner;
        if (!zone_active)
            eff_step = '0;
        else if (step_cfg > CLAMP_V)
            eff_step = CLAMP_V;
        else
            eff_step = step_cfg;
    end

    always_ff @(posedge clk) begin
        if (rst)
            reduce_current <= 1'b0;
        else
            reduce_current <= inner;
    end

endmodule

// File: rtl/flux_precomp_pulse.sv
module flux_precomp_pulse
    import flux_precomp_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int PW     = 4,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  cell_class_t       cls,
    input  logic [STEP_W-1:0] eff_step,
    output logic              wr_pulse
);

    localparam int PH_W      = $clog2(OVS);
    localparam int NOM_START = (OVS - PW) / 2;

    localparam logic [PH_W:0]   NOM_X  = (PH_W+1)'(NOM_START);
    localparam logic [PH_W:0]   PW_X   = (PH_W+1)'(PW);
    localparam logic [PH_W-1:0] LAST_P = PH_W'(OVS - 1);

    typedef struct packed {
        logic          fire;
        logic [PH_W:0] start;
    } plan_t;

    plan_t           plan_d, plan_q;
    logic [PH_W-1:0] phase_q;
    logic            run_q;
    logic [PH_W:0]   step_x;
    logic [PH_W:0]   phase_x;
    logic            in_win;

    always_comb begin
        step_x      = (PH_W+1)'(eff_step);
        plan_d.fire = cls.fire;
        unique case (cls.dir)
            SHIFT_LATE:  plan_d.start = NOM_X + step_x;
            SHIFT_EARLY: plan_d.start = NOM_X - step_x;
            default:     plan_d.start = NOM_X;
        endcase
    end

    always_comb begin
        phase_x = {1'b0, phase_q};
        in_win  = (phase_x >= plan_q.start) && (phase_x < plan_q.start + PW_X);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q   <= '0;
            phase_q  <= '0;
            run_q    <= 1'b0;
            wr_pulse <= 1'b0;
        end else begin
            wr_pulse <= run_q && plan_q.fire && in_win;
            if (strobe) begin
                plan_q  <= plan_d;
                phase_q <= '0;
                run_q   <= 1'b1;
            end else if (run_q) begin
                if (phase_q == LAST_P)
                    run_q <= 1'b0;
                else
                    phase_q <= phase_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/flux_precomp.sv
module flux_precomp
    import flux_precomp_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int PW          = 4,
    parameter int TRK_W       = 8,
    parameter int STEP_W      = 3,
    parameter int TRACK_LIMIT = 43
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [TRK_W-1:0]  track,
    input  logic [STEP_W-1:0] step_cfg,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              wr_pulse,
    output logic              reduce_current
);

    localparam int MAX_STEP = (OVS - PW) / 2;

    cell_class_t       cls_next;
    logic              zone_active;
    logic [STEP_W-1:0] eff_step;

    flux_precomp_window u_window (
        .clk      (clk),
        .rst      (rst),
        .strobe   (bit_valid),
        .bit_in   (bit_in),
        .cls_next (cls_next)
    );

    flux_precomp_zone #(
        .TRK_W       (TRK_W),
        .STEP_W      (STEP_W),
        .TRACK_LIMIT (TRACK_LIMIT),
        .MAX_STEP    (MAX_STEP)
    ) u_zone (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .track          (track),
        .step_cfg       (step_cfg),
        .zone_active    (zone_active),
        .eff_step       (eff_step),
        .reduce_current (reduce_current)
    );

    flux_precomp_pulse #(
        .OVS    (OVS),
        .PW     (PW),
        .STEP_W (STEP_W)
    ) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .strobe   (bit_valid),
        .cls      (cls_next),
        .eff_step (eff_step),
        .wr_pulse (wr_pulse)
    );

endmodule

// File: rtl/flux_precomp_chk.sv
module flux_precomp_chk #(
    parameter int PW          = 4,
    parameter int TRK_W       = 8,
    parameter int STEP_W      = 3,
    parameter int TRACK_LIMIT = 43,
    parameter int MAX_STEP    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_valid,
    input logic [TRK_W-1:0]  track,
    input logic              wr_pulse,
    input logic              reduce_current,
    input logic              zone_active,
    input logic [STEP_W-1:0] eff_step
);

    localparam int CW = $clog2(PW + 2) + 1;

    logic          past_ok;
    logic          prev_p;
    logic [CW-1:0] hi_len;
    logic [1:0]    rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
            prev_p  <= 1'b0;
            hi_len  <= '0;
            rises   <= '0;
        end else begin
            past_ok <= 1'b1;
            prev_p  <= wr_pulse;
            if (!wr_pulse)
                hi_len <= '0;
            else if (hi_len != CW'(PW + 1))
                hi_len <= hi_len + 1'b1;
            if (bit_valid)
                rises <= '0;
            else if (wr_pulse && !prev_p && rises != 2'd3)
                rises <= rises + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wr_pulse && !reduce_current)); // R1

    AST_REDUCE_FOLLOWS_TRACK: assert property (@(posedge clk) disable iff (rst || !past_ok)
        reduce_current == ($past(track) > TRK_W'(TRACK_LIMIT))); // R2

    AST_PULSE_WIDTH_EXACT: assert property (@(posedge clk) disable iff (rst)
        (!wr_pulse && hi_len != '0) |-> hi_len == CW'(PW)); // R3

    AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
        hi_len <= CW'(PW)); // R3

    AST_ONE_PULSE_PER_CELL: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && !prev_p) |-> rises == 2'd0); // R4

    AST_NO_STEP_LOW_TRACK: assert property (@(posedge clk) disable iff (rst)
        (track <= TRK_W'(TRACK_LIMIT)) |-> (eff_step == '0 && !zone_active)); // R8

    AST_STEP_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        eff_step <= STEP_W'(MAX_STEP)); // R10

endmodule

bind flux_precomp flux_precomp_chk #(
    .PW          (PW),
    .TRK_W       (TRK_W),
    .STEP_W      (STEP_W),
    .TRACK_LIMIT (TRACK_LIMIT),
    .MAX_STEP    (MAX_STEP)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bit_valid      (bit_valid),
    .track          (track),
    .wr_pulse       (wr_pulse),
    .reduce_current (reduce_current),
    .zone_active    (zone_active),
    .eff_step       (eff_step)
);

// File: tb/flux_precomp_bench.sv
`timescale 1ns/1ps
module flux_precomp_bench;

    localparam int OVS   = 16;
    localparam int PW    = 4;
    localparam int NOM   = 6;
    localparam int MAXS  = 6;
    localparam int LIMIT = 43;
    localparam int NB    = 18;
    localparam logic [7:0] DB = 8'b0001_1101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [7:0] track = '0;
    logic [2:0] step_cfg = '0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       wr_pulse;
    logic       reduce_current;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flux_precomp u_flux_precomp (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .track          (track),
        .step_cfg       (step_cfg),
        .bit_valid      (bit_valid),
        .bit_in         (bit_in),
        .wr_pulse       (wr_pulse),
        .reduce_current (reduce_current)
    );

    function automatic logic getbit(int j, int rot);
        if (j < 0) return 1'b0;
        return DB[7 - ((j + rot) % 8)];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected 16-tick waveform and requirement tag for cell c.
    task automatic cell_check(int c, int rot, bit en, int trk, int stp, logic [15:0] obs);
        logic p, cu, nx;
        bit   act;
        int   s, st;
        logic [15:0] ev;
        string tag;
        p  = getbit(c - 2, rot);
        cu = getbit(c - 1, rot);
        nx = getbit(c, rot);
        act = en && (trk > LIMIT);
        s  = act ? ((stp > MAXS) ? MAXS : stp) : 0;
        st = NOM;
        tag = "R7";
        if (!cu) tag = "R3";
        else if (p && !nx) begin
            st = NOM + s;
            tag = !en ? "R9" : (trk <= LIMIT) ? "R8" : (stp > MAXS || stp == 0) ? "R10" : "R5";
        end else if (!p && nx) begin
            st = NOM - s;
            tag = !en ? "R9" : (trk <= LIMIT) ? "R8" : (stp > MAXS || stp == 0) ? "R10" : "R6";
        end
        for (int i = 0; i < 16; i++)
            ev[i] = cu && (i >= st) && (i < st + PW);
        if (obs != ev)
            $display("FAIL detail: cell %0d window p/c/n=%0b%0b%0b (R4 cell timing)", c, p, cu, nx);
        check(obs == ev, tag, obs, ev);
    endtask

    task automatic run_config(bit en, int trk, int stp, int rot);
        logic [15:0] obs;
        int idle_hits;
        enable   = en;
        track    = 8'(trk);
        step_cfg = 3'(stp);
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in    = 1'b0;
        rst       = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(!wr_pulse && !reduce_current, "R1", {wr_pulse, reduce_current}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(reduce_current == (trk > LIMIT), "R2", reduce_current, (trk > LIMIT));
        obs = '0;
        for (int k = 0; k <= NB + 1; k++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in    = getbit(k, rot);
            @(posedge clk);
            #1;
            if (k > 0) begin
                obs[15] = wr_pulse;
                cell_check(k - 1, rot, en, trk, stp, obs);
            end
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in    = 1'b0;
            for (int m = 1; m <= 15; m++) begin
                @(posedge clk);
                #1;
                obs[m - 1] = wr_pulse;
            end
        end
        @(posedge clk);
        #1;
        obs[15] = wr_pulse;
        cell_check(NB + 1, rot, en, trk, stp, obs);
        idle_hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #1;
            if (wr_pulse) idle_hits++;
        end
        check(idle_hits == 0, "R11", idle_hits, 0);
        @(negedge clk);
        track = 8'(trk > LIMIT ? 10 : 90);
        @(posedge clk);
        #1;
        check(reduce_current == (trk <= LIMIT), "R2", reduce_current, (trk <= LIMIT));
    endtask

    initial begin
        run_config(1'b1, 44, 2, 0);
        run_config(1'b1, 43, 2, 3);
        run_config(1'b0, 79, 3, 1);
        run_config(1'b1, 79, 7, 5);
        run_config(1'b1, 60, 0, 2);
        run_config(1'b1, 100, 6, 6);
        run_config(1'b1, 0, 5, 4);
        run_config(1'b1, 255, 4, 7);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule